// File: doc/BRIEF.md
# Host Session Connect and Reset Timer

This block runs the host side of a power session after a power request has turned the VBUS supply on. With VBUS up, it waits a bounded, programmable time for a peripheral to signal a connect by pulling D+ high. Once D+ is high, it requires an unbroken debounce interval before it drives a bus reset (SE0) for a programmable width. It then stays in a connected state for as long as D+ stays high.

A disconnect does not cut power at once. The block returns to waiting with VBUS still on, and a fresh wait window starts. If that window expires, or if the session-valid comparator drops while VBUS is enabled, the block drops the VBUS enable. When the comparator reports that the line has fallen below the session-valid level, the block issues a one-cycle session-end pulse, so that the probe sequencer can start a new probe. All timing counts a one-millisecond tick input. The three limits are inputs, so the connect window (30000 ms by default), the debounce (100 ms) and the reset width (50 ms) can be set by the surrounding logic.

Top module: `host_session_ctl`

## Requirements
- R1: After reset the state is IDLE, and vbusEn, busResetDrive and sessionEnd are all low.
- R2: In IDLE with powerReq high, the next cycle is WAIT_CONNECT with vbusEn high. vbusEn only rises after a cycle in which powerReq was high.
- R3: In WAIT_CONNECT with D+ low, the block moves to SHUTDOWN (vbusEn low) on exactly the cfgConnectLimit-th msTick. It is still in WAIT_CONNECT after one tick fewer.
- R4: D+ high in WAIT_CONNECT moves the block to DEBOUNCE on the next cycle. RESET is entered on the cfgDebounce-th consecutive msTick seen with D+ high, and not earlier.
- R5: If D+ goes low during DEBOUNCE, the debounce count restarts from zero and no reset is driven.
- R6: In RESET, busResetDrive is high and vbusEn stays high. D+ is ignored. After cfgResetWidth ticks the block enters CONNECTED with busResetDrive low.
- R7: D+ low in CONNECTED returns the block to WAIT_CONNECT with vbusEn still high and a fresh cfgConnectLimit window.
- R8: In SHUTDOWN, vbusEn is low until sessValid is low. The block then returns to IDLE with sessionEnd high for exactly one cycle, and vbusEn low during that cycle.
- R9: A falling edge of sessValid while vbusEn is high forces SHUTDOWN on the next cycle.
- R10: stateOneHot has exactly one bit set: bit 0 IDLE, bit 1 WAIT_CONNECT, bit 2 DEBOUNCE, bit 3 RESET, bit 4 CONNECTED, bit 5 SHUTDOWN.
- R11: In DEBOUNCE, ticks with D+ low count toward the connect window, which restarts when DEBOUNCE is entered. Reaching cfgConnectLimit there moves the block to SHUTDOWN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| dpConnect | input | 1 | Debounced D+ pull-up state (1 = connected) |
| sessValid | input | 1 | VBUS above the session-valid level |
| powerReq | input | 1 | Request to start a session |
| cfgConnectLimit | input | 16 | Connect wait window in ms |
| cfgDebounce | input | 16 | Minimum stable connect before reset, in ms |
| cfgResetWidth | input | 16 | Bus reset width in ms |
| vbusEn | output | 1 | VBUS supply enable |
| busResetDrive | output | 1 | Drive SE0 bus reset |
| sessionEnd | output | 1 | One-cycle pulse when the session has ended |
| stateOneHot | output | 6 | One-hot state status |

## Verification
The assertions check the following on every cycle:
- the status stays one-hot;
- a reset is driven only with VBUS on;
- the session-end pulse is one cycle long, with VBUS off;
- VBUS rises only after a power request;
- a session-valid drop cuts VBUS on the next cycle;
- no reset begins before the debounce count of stable connect ticks;
- the wait window is never overrun.

The exact tick on which each timeout fires, the restart of the debounce after a glitch, the fresh window after a disconnect, and the order of transitions over a whole session can only be shown by the bench. It does this by sweeping the debounce and reset widths against a small connect window.

// File: rtl/host_sess_pkg.sv
package host_sess_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_DEB  = 3'd2,
    ST_RST  = 3'd3,
    ST_CONN = 3'd4,
    ST_SHUT = 3'd5
  } sessState_t;

  localparam int NUM_STATES = 6;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clrAll;    // state change: restart both counters
    logic cntWait;   // count ticks in the connect window
    logic cntPhase;  // count ticks in debounce or reset
    logic clrPhase;  // restart the phase counter
  } timerCtl_t;

endpackage

// File: rtl/host_sess_timer.sv
module host_sess_timer
  import host_sess_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  timerCtl_t        ctl,
  input  logic [CNT_W-1:0] cfgConnectLimit,
  input  logic [CNT_W-1:0] cfgDebounce,
  input  logic [CNT_W-1:0] cfgResetWidth,
  output logic             waitDone,
  output logic             debDone,
  output logic             rstDone
);

  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W:0]   waitNext;
  logic [CNT_W:0]   phaseNext;

  assign waitNext  = {1'b0, waitCnt} + ONE;
  assign phaseNext = {1'b0, phaseCnt} + ONE;

  // a limit is reached on the tick that brings the count up to it
  assign waitDone = msTick && (waitNext >= {1'b0, cfgConnectLimit});
  assign debDone  = msTick && (phaseNext >= {1'b0, cfgDebounce});
  assign rstDone  = msTick && (phaseNext >= {1'b0, cfgResetWidth});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (ctl.clrAll) begin
      waitCnt <= '0;
    end else if (ctl.cntWait && msTick && waitCnt != CNT_MAX) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (ctl.clrAll || ctl.clrPhase) begin
      phaseCnt <= '0;
    end else if (ctl.cntPhase && msTick && phaseCnt != CNT_MAX) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

endmodule

// File: rtl/host_sess_fsm.sv
module host_sess_fsm
  import host_sess_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dpConnect,
  input  logic                  sessValid,
  input  logic                  powerReq,
  input  logic                  waitDone,
  input  logic                  debDone,
  input  logic                  rstDone,
  output timerCtl_t             ctl,
  output logic                  vbusEn,
  output logic                  busResetDrive,
  output logic                  sessionEnd,
  output logic [NUM_STATES-1:0] stateOneHot
);

  sessState_t state, nxt;
  logic sessValidQ;
  logic sessFall;

  assign vbusEn = (state == ST_WAIT) || (state == ST_DEB) ||
                  (state == ST_RST)  || (state == ST_CONN);
  assign busResetDrive = (state == ST_RST);
  assign sessFall = vbusEn && sessValidQ && !sessValid;

  always_comb begin
    nxt          = state;
    ctl.cntWait  = 1'b0;
    ctl.cntPhase = 1'b0;
    ctl.clrPhase = 1'b0;
    unique case (state)
      ST_IDLE: if (powerReq) nxt = ST_WAIT;
      ST_WAIT: begin
        ctl.cntWait = 1'b1;
        if (dpConnect)     nxt = ST_DEB;
        else if (waitDone) nxt = ST_SHUT;
      end
      ST_DEB: begin
        if (dpConnect) begin
          ctl.cntPhase = 1'b1;
          if (debDone) nxt = ST_RST;
        end else begin
          ctl.clrPhase = 1'b1;
          ctl.cntWait  = 1'b1;
          if (waitDone) nxt = ST_SHUT;
        end
      end
      ST_RST: begin
        ctl.cntPhase = 1'b1;
        if (rstDone) nxt = ST_CONN;
      end
      ST_CONN: if (!dpConnect) nxt = ST_WAIT;
      ST_SHUT: if (!sessValid) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (sessFall) nxt = ST_SHUT;
    ctl.clrAll = (nxt != state);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sessValidQ <= 1'b0;
      sessionEnd <= 1'b0;
    end else begin
      state      <= nxt;
      sessValidQ <= sessValid;
      sessionEnd <= (state == ST_SHUT) && (nxt == ST_IDLE);
    end
  end

  always_comb begin
    stateOneHot = '0;
    stateOneHot[state] = 1'b1;
  end

endmodule

// File: rtl/host_session_ctl.sv
module host_session_ctl
  import host_sess_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             dpConnect,
  input  logic             sessValid,
  input  logic             powerReq,
  input  logic [CNT_W-1:0] cfgConnectLimit,
  input  logic [CNT_W-1:0] cfgDebounce,
  input  logic [CNT_W-1:0] cfgResetWidth,
  output logic             vbusEn,
  output logic             busResetDrive,
  output logic             sessionEnd,
  output logic [5:0]       stateOneHot
);

  timerCtl_t ctl;
  logic waitDone, debDone, rstDone;

  host_sess_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ctl(ctl),
    .cfgConnectLimit(cfgConnectLimit), .cfgDebounce(cfgDebounce),
    .cfgResetWidth(cfgResetWidth),
    .waitDone(waitDone), .debDone(debDone), .rstDone(rstDone)
  );

  host_sess_fsm u_fsm (
    .clk(clk), .rstN(rstN), .dpConnect(dpConnect), .sessValid(sessValid),
    .powerReq(powerReq), .waitDone(waitDone), .debDone(debDone),
    .rstDone(rstDone), .ctl(ctl), .vbusEn(vbusEn),
    .busResetDrive(busResetDrive), .sessionEnd(sessionEnd),
    .stateOneHot(stateOneHot)
  );

endmodule

// File: rtl/host_sess_chk.sv
module host_sess_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             msTick,
  input logic             dpConnect,
  input logic             sessValid,
  input logic             powerReq,
  input logic [CNT_W-1:0] cfgConnectLimit,
  input logic [CNT_W-1:0] cfgDebounce,
  input logic             vbusEn,
  input logic             busResetDrive,
  input logic             sessionEnd,
  input logic [5:0]       stateOneHot
);

  localparam logic [CNT_W:0] RUN_MAX = '1;

  logic [CNT_W:0] dpRun;    // consecutive ticks with D+ high
  logic [CNT_W:0] waitRun;  // consecutive ticks powered, unconnected, not in reset

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpRun   <= '0;
      waitRun <= '0;
    end else begin
      if (!dpConnect) dpRun <= '0;
      else if (msTick && dpRun != RUN_MAX) dpRun <= dpRun + 1'b1;
      if (dpConnect || busResetDrive || !vbusEn) waitRun <= '0;
      else if (msTick && waitRun != RUN_MAX) waitRun <= waitRun + 1'b1;
    end
  end

  // R10
  onehot_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateOneHot) == 1);

  // R6
  reset_needs_vbus_chk: assert property (@(posedge clk) disable iff (!rstN)
    busResetDrive |-> vbusEn);

  // R8
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sessionEnd |=> !sessionEnd);

  // R8
  end_vbus_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    sessionEnd |-> !vbusEn);

  // R2
  vbus_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vbusEn) |-> $past(powerReq));

  // R9
  sess_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vbusEn && $fell(sessValid)) |=> !vbusEn);

  // R4
  debounce_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busResetDrive) |-> (dpRun >= {1'b0, cfgDebounce}));

  // R3
  wait_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitRun <= ({1'b0, cfgConnectLimit} + 1'b1));

endmodule

bind host_session_ctl host_sess_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .msTick(msTick), .dpConnect(dpConnect),
  .sessValid(sessValid), .powerReq(powerReq),
  .cfgConnectLimit(cfgConnectLimit), .cfgDebounce(cfgDebounce),
  .vbusEn(vbusEn), .busResetDrive(busResetDrive),
  .sessionEnd(sessionEnd), .stateOneHot(stateOneHot)
);

// File: tb/host_session_ctl_tb.sv
module host_session_ctl_tb;

  localparam logic [5:0] S_IDLE = 6'b000001;
  localparam logic [5:0] S_WAIT = 6'b000010;
  localparam logic [5:0] S_DEB  = 6'b000100;
  localparam logic [5:0] S_RST  = 6'b001000;
  localparam logic [5:0] S_CONN = 6'b010000;
  localparam logic [5:0] S_SHUT = 6'b100000;
  localparam int LIMIT = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, dpConnect = 1'b0, sessValid = 1'b0, powerReq = 1'b0;
  logic [15:0] cfgConnectLimit = 16'(LIMIT);
  logic [15:0] cfgDebounce = 16'd1;
  logic [15:0] cfgResetWidth = 16'd1;
  logic vbusEn, busResetDrive, sessionEnd;
  logic [5:0] stateOneHot;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  host_session_ctl u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .dpConnect(dpConnect),
    .sessValid(sessValid), .powerReq(powerReq),
    .cfgConnectLimit(cfgConnectLimit), .cfgDebounce(cfgDebounce),
    .cfgResetWidth(cfgResetWidth), .vbusEn(vbusEn),
    .busResetDrive(busResetDrive), .sessionEnd(sessionEnd),
    .stateOneHot(stateOneHot)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkState(input logic [5:0] exp, input string tag);
    check(stateOneHot === exp, tag, int'(stateOneHot), int'(exp));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) msTick = 1'b1;
    @(negedge clk) msTick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic startSession();
    powerReq = 1'b1;
    step();
    chkState(S_WAIT, "R2 start");
    check(vbusEn === 1'b1, "R2 vbusEn on", int'(vbusEn), 1);
    powerReq = 1'b0;
    sessValid = 1'b1;
    step();
  endtask

  task automatic endSession(input string tag);
    sessValid = 1'b0;
    step();
    chkState(S_IDLE, tag);
    check(sessionEnd === 1'b1, "R8 end pulse", int'(sessionEnd), 1);
    step();
    check(sessionEnd === 1'b0, "R8 pulse one cycle", int'(sessionEnd), 0);
  endtask

  task automatic runCase(input int deb, input int rw);
    cfgDebounce = 16'(deb);
    cfgResetWidth = 16'(rw);
    // R3 connect window expiry
    startSession();
    ticks(LIMIT - 1);
    chkState(S_WAIT, "R3 before limit");
    tick();
    chkState(S_SHUT, "R3 at limit");
    check(vbusEn === 1'b0, "R3 vbus off", int'(vbusEn), 0);
    step();
    chkState(S_SHUT, "R8 hold while sess valid");
    endSession("R8 back to idle");
    // R4/R5 debounce with a glitch
    startSession();
    dpConnect = 1'b1;
    step();
    chkState(S_DEB, "R4 connect");
    ticks(deb - 1);
    chkState(S_DEB, "R4 before debounce");
    dpConnect = 1'b0;
    step();
    dpConnect = 1'b1;
    step();
    ticks(deb - 1);
    chkState(S_DEB, "R5 glitch restarts");
    check(busResetDrive === 1'b0, "R5 no reset", int'(busResetDrive), 0);
    tick();
    chkState(S_RST, "R4 reset entry");
    check(busResetDrive === 1'b1, "R6 reset drive", int'(busResetDrive), 1);
    // R6 reset width, D+ low during SE0 ignored
    dpConnect = 1'b0;
    ticks(rw - 1);
    chkState(S_RST, "R6 before width");
    dpConnect = 1'b1;
    tick();
    chkState(S_CONN, "R6 connected");
    check(busResetDrive === 1'b0, "R6 reset released", int'(busResetDrive), 0);
    // R7 disconnect keeps VBUS with fresh window
    dpConnect = 1'b0;
    step();
    chkState(S_WAIT, "R7 disconnect");
    check(vbusEn === 1'b1, "R7 vbus kept", int'(vbusEn), 1);
    ticks(LIMIT - 1);
    chkState(S_WAIT, "R7 fresh window");
    // R11 window counts in debounce with D+ low
    dpConnect = 1'b1;
    step();
    chkState(S_DEB, "R11 reconnect");
    dpConnect = 1'b0;
    ticks(LIMIT - 1);
    chkState(S_DEB, "R11 before limit");
    tick();
    chkState(S_SHUT, "R11 window expiry");
    endSession("R8 idle after R11");
    // R9 comparator drop
    startSession();
    step();
    sessValid = 1'b0;
    step();
    chkState(S_SHUT, "R9 forced shutdown");
    step();
    chkState(S_IDLE, "R9 idle");
    check(sessionEnd === 1'b1, "R9 end pulse", int'(sessionEnd), 1);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chkState(S_IDLE, "R1 reset state");
    check({vbusEn, busResetDrive, sessionEnd} === 3'b000, "R1 outputs low",
          int'({vbusEn, busResetDrive, sessionEnd}), 0);
    rstN = 1'b1;
    step();
    chkState(S_IDLE, "R1 idle without request");
    check(stateOneHot === S_IDLE, "R10 encoding", int'(stateOneHot), int'(S_IDLE));
    for (int d = 1; d <= 4; d++) begin
      for (int w = 1; w <= 3; w++) begin
        runCase(d, w);
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule